// File: doc/BRIEF.md
# Bus Transaction Watchdog with Error Capture

This block sits beside a shared multi-master bus and watches one transaction at a time. Each grant starts a cycle counter. If the addressed target neither acknowledges nor aborts within a programmable number of cycles, the block ends the transaction toward the master with an error response, so the bus cannot hang. A target abort is the second kind of failure it detects. Arbitration, address decoding and the host's fault handling are outside the block.

On the first failure the block freezes a capture record: the full address, split into a low and a high 32-bit word; the direction; the byte strobes; the issuing master as a one-hot vector; and the cause. It also raises the matching interrupt line, one line for timeouts and one for aborts. The record and the interrupt are held, and later failures are ignored, until software writes a release command. Software reads the record through a small word-indexed register port with a combinational read path.

Top module: `bus_err_monitor`

## Requirements
- R1: After reset both interrupts are low, `bus_err_resp` is low, the status word (index 4) reads 0 and the limit register (index 0) reads the `TMO_RST` parameter (1024 by default).
- R2: Writing the limit register (index 0) loads a new cycle limit, but the values 0 and 32'hFFFF_FFFF are discarded and the old limit is kept.
- R3: With a limit of T, if a granted transaction sees neither `tgt_ack` nor `tgt_abort` in the T cycles that follow its grant cycle, `bus_err_resp` is high in the T-th of those cycles and the transaction ends.
- R4: A response (`tgt_ack` or `tgt_abort`) in the cycle where the limit is reached takes priority, so no error response and no timeout capture occur.
- R5: A new grant while a transaction is outstanding restarts the count from the new grant cycle.
- R6: `tgt_abort` while a transaction is outstanding records a target-abort capture.
- R7: Capture fields: the status word has bit 0 valid, bit 1 write, bits 5:2 byte strobes, bit 11 target abort and bit 12 timeout. Index 3 holds address bits 31:0, index 2 holds the upper address bits zero-extended, and index 5 holds the master vector with only bit `mon_mid` set.
- R8: While a capture is valid, later errors do not change any captured field.
- R9: `irq_timeout` equals valid AND the timeout cause, and `irq_abort` equals valid AND the abort cause. Both are low in the cycle after a release.
- R10: Writing the release register (index 1) with bit 0 set drops the valid bit. A write with bit 0 clear has no effect.
- R11: When a release and a new error fall in the same cycle, the new error is captured and valid stays set.
- R12: While no capture is valid, the status word reads 0 and neither interrupt is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_grant | input | 1 | A transaction is granted this cycle |
| mon_addr | input | ADDR_W | Address of the granted transaction |
| mon_write | input | 1 | Granted transaction is a write |
| mon_strb | input | 4 | Byte strobes of the granted transaction |
| mon_mid | input | MID_W | Index of the granted master |
| tgt_ack | input | 1 | Target completes the outstanding transaction |
| tgt_abort | input | 1 | Target aborts the outstanding transaction |
| bus_err_resp | output | 1 | Timeout error response toward the master |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_timeout | output | 1 | Timeout capture interrupt |
| irq_abort | output | 1 | Target-abort capture interrupt |

## Verification
Two pairs of events can coincide. In the first, a target response lands in the very cycle the limit is reached. The bench provokes this by acknowledging exactly T cycles after a grant, and it requires no error response, no capture and no interrupt. In the second, a software release lands in the same cycle as a new timeout. The bench issues the release write in the expiry cycle, and it requires the interrupt to stay high and the status, address and master words to show the new transaction's fields. A cycle-level reference model in the bench judges the error response and both interrupts on every clock.

// File: rtl/bw_pkg.sv
package bw_pkg;
  // Register word indices
  typedef enum logic [2:0] {
    RA_LIMIT   = 3'd0,
    RA_RELEASE = 3'd1,
    RA_ADDR_HI = 3'd2,
    RA_ADDR_LO = 3'd3,
    RA_STATUS  = 3'd4,
    RA_MASTER  = 3'd5
  } reg_idx_e;

  // Status word bit positions
  localparam int ST_VALID    = 0;
  localparam int ST_WRITE    = 1;
  localparam int ST_STRB_LSB = 2;
  localparam int STRB_W      = 4;
  localparam int ST_ABORT    = 11;
  localparam int ST_TMO      = 12;

  localparam int REG_W  = 32;
  localparam int MVEC_W = 32;
endpackage

// File: rtl/bw_rst_sync.sv
module bw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/bw_txn_timer.sv
module bw_txn_timer
  import bw_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int MID_W  = 4,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant,
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic [STRB_W-1:0] strb,
  input  logic [MID_W-1:0]  mid,
  input  logic              ack,
  input  logic              abort,
  input  logic [CNT_W-1:0]  limit,
  output logic              busy,
  output logic              expire,
  output logic              abort_hit,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              cur_write,
  output logic [STRB_W-1:0] cur_strb,
  output logic [MID_W-1:0]  cur_mid
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             rsp;
  logic             at_limit;

  logic [ADDR_W-1:0] addr_q;
  logic              write_q;
  logic [STRB_W-1:0] strb_q;
  logic [MID_W-1:0]  mid_q;

  assign rsp      = ack | abort;
  assign at_limit = (cnt_q >= (limit - {{(CNT_W-1){1'b0}}, 1'b1}));

  // The response has priority over expiry in the same cycle
  always_comb begin
    expire    = busy_q & ~rsp & at_limit;
    abort_hit = busy_q & abort;
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = grant | busy_q;
    if (grant) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (rsp || expire) busy_d = 1'b0;
      cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      write_q <= 1'b0;
      strb_q  <= '0;
      mid_q   <= '0;
    end else if (grant) begin
      addr_q  <= addr;
      write_q <= write;
      strb_q  <= strb;
      mid_q   <= mid;
    end
  end

  assign busy      = busy_q;
  assign cur_addr  = addr_q;
  assign cur_write = write_q;
  assign cur_strb  = strb_q;
  assign cur_mid   = mid_q;
endmodule

// File: rtl/bw_err_capture.sv
module bw_err_capture
  import bw_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int MID_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmo_evt,
  input  logic              abort_evt,
  input  logic              release_cmd,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              cur_write,
  input  logic [STRB_W-1:0] cur_strb,
  input  logic [MID_W-1:0]  cur_mid,
  output logic              cap_valid,
  output logic              cap_tmo,
  output logic              cap_abort,
  output logic              cap_write,
  output logic [STRB_W-1:0] cap_strb,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [MVEC_W-1:0] cap_master
);
  localparam int NUM_MST = 1 << MID_W;

  logic              valid_q, valid_d;
  logic              load;
  logic              tmo_q, abort_q, write_q;
  logic [STRB_W-1:0] strb_q;
  logic [ADDR_W-1:0] addr_q;
  logic [MVEC_W-1:0] master_q, master_oh;

  // One-hot master vector from the index
  for (genvar g = 0; g < MVEC_W; g++) begin : g_oh
    if (g < NUM_MST) begin : g_used
      assign master_oh[g] = (cur_mid == MID_W'(g));
    end else begin : g_unused
      assign master_oh[g] = 1'b0;
    end
  end

  // A release frees the slot for an error arriving in the same cycle
  always_comb begin
    load    = (tmo_evt | abort_evt) & (~valid_q | release_cmd);
    valid_d = valid_q;
    if (load)             valid_d = 1'b1;
    else if (release_cmd) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q    <= 1'b0;
      abort_q  <= 1'b0;
      write_q  <= 1'b0;
      strb_q   <= '0;
      addr_q   <= '0;
      master_q <= '0;
    end else if (load) begin
      tmo_q    <= tmo_evt;
      abort_q  <= abort_evt & ~tmo_evt;
      write_q  <= cur_write;
      strb_q   <= cur_strb;
      addr_q   <= cur_addr;
      master_q <= master_oh;
    end
  end

  assign cap_valid  = valid_q;
  assign cap_tmo    = tmo_q;
  assign cap_abort  = abort_q;
  assign cap_write  = write_q;
  assign cap_strb   = strb_q;
  assign cap_addr   = addr_q;
  assign cap_master = master_q;
endmodule

// File: rtl/bw_regs.sv
module bw_regs
  import bw_pkg::*;
#(
  parameter int              ADDR_W  = 40,
  parameter logic [REG_W-1:0] TMO_RST = 32'd1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              cap_valid,
  input  logic              cap_tmo,
  input  logic              cap_abort,
  input  logic              cap_write,
  input  logic [STRB_W-1:0] cap_strb,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [MVEC_W-1:0] cap_master,
  output logic [REG_W-1:0]  rdata,
  output logic [REG_W-1:0]  limit,
  output logic              release_cmd
);
  localparam int HI_W = ADDR_W - 32;

  logic [REG_W-1:0] limit_q, limit_d;
  logic             limit_en;
  logic [REG_W-1:0] status_w;
  reg_idx_e         idx;

  assign idx = reg_idx_e'(addr);

  // Zero and all-ones are not accepted as limits
  always_comb begin
    limit_en    = we && (idx == RA_LIMIT) && (wdata != '0) && (wdata != '1);
    limit_d     = wdata;
    release_cmd = we && (idx == RA_RELEASE) && wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        limit_q <= TMO_RST;
    else if (limit_en) limit_q <= limit_d;
  end

  always_comb begin
    status_w = '0;
    if (cap_valid) begin
      status_w[ST_VALID]                     = 1'b1;
      status_w[ST_WRITE]                     = cap_write;
      status_w[ST_STRB_LSB +: STRB_W]        = cap_strb;
      status_w[ST_ABORT]                     = cap_abort;
      status_w[ST_TMO]                       = cap_tmo;
    end
  end

  always_comb begin
    unique case (idx)
      RA_LIMIT:   rdata = limit_q;
      RA_ADDR_HI: rdata = {{(REG_W-HI_W){1'b0}}, cap_addr[ADDR_W-1:32]};
      RA_ADDR_LO: rdata = cap_addr[31:0];
      RA_STATUS:  rdata = status_w;
      RA_MASTER:  rdata = cap_master;
      default:    rdata = '0;
    endcase
  end

  assign limit = limit_q;
endmodule

// File: rtl/bus_err_monitor.sv
module bus_err_monitor
  import bw_pkg::*;
#(
  parameter int               ADDR_W  = 40,
  parameter int               MID_W   = 4,
  parameter logic [REG_W-1:0] TMO_RST = 32'd1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mon_grant,
  input  logic [ADDR_W-1:0] mon_addr,
  input  logic              mon_write,
  input  logic [3:0]        mon_strb,
  input  logic [MID_W-1:0]  mon_mid,
  input  logic              tgt_ack,
  input  logic              tgt_abort,
  output logic              bus_err_resp,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_timeout,
  output logic              irq_abort
);
  logic              rst_n_s;
  logic              txn_busy, tmo_evt, abort_evt, release_cmd;
  logic [ADDR_W-1:0] cur_addr, cap_addr;
  logic              cur_write, cap_write;
  logic [STRB_W-1:0] cur_strb, cap_strb;
  logic [MID_W-1:0]  cur_mid;
  logic              cap_valid, cap_tmo, cap_abort;
  logic [MVEC_W-1:0] cap_master;
  logic [REG_W-1:0]  limit;

  bw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  bw_txn_timer #(.ADDR_W(ADDR_W), .MID_W(MID_W), .CNT_W(REG_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .grant     (mon_grant),
    .addr      (mon_addr),
    .write     (mon_write),
    .strb      (mon_strb),
    .mid       (mon_mid),
    .ack       (tgt_ack),
    .abort     (tgt_abort),
    .limit     (limit),
    .busy      (txn_busy),
    .expire    (tmo_evt),
    .abort_hit (abort_evt),
    .cur_addr  (cur_addr),
    .cur_write (cur_write),
    .cur_strb  (cur_strb),
    .cur_mid   (cur_mid)
  );

  bw_err_capture #(.ADDR_W(ADDR_W), .MID_W(MID_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .tmo_evt     (tmo_evt),
    .abort_evt   (abort_evt),
    .release_cmd (release_cmd),
    .cur_addr    (cur_addr),
    .cur_write   (cur_write),
    .cur_strb    (cur_strb),
    .cur_mid     (cur_mid),
    .cap_valid   (cap_valid),
    .cap_tmo     (cap_tmo),
    .cap_abort   (cap_abort),
    .cap_write   (cap_write),
    .cap_strb    (cap_strb),
    .cap_addr    (cap_addr),
    .cap_master  (cap_master)
  );

  bw_regs #(.ADDR_W(ADDR_W), .TMO_RST(TMO_RST)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .we          (reg_we),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .cap_valid   (cap_valid),
    .cap_tmo     (cap_tmo),
    .cap_abort   (cap_abort),
    .cap_write   (cap_write),
    .cap_strb    (cap_strb),
    .cap_addr    (cap_addr),
    .cap_master  (cap_master),
    .rdata       (reg_rdata),
    .limit       (limit),
    .release_cmd (release_cmd)
  );

  assign bus_err_resp = tmo_evt;
  assign irq_timeout  = cap_valid & cap_tmo;
  assign irq_abort    = cap_valid & cap_abort;
endmodule

// File: rtl/bus_err_monitor_checker.sv
module bus_err_monitor_checker #(
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_timeout,
  input logic              irq_abort,
  input logic              bus_err_resp,
  input logic              txn_busy,
  input logic              tgt_ack,
  input logic              tgt_abort,
  input logic              tmo_evt,
  input logic              abort_evt,
  input logic              release_cmd,
  input logic              cap_valid,
  input logic [31:0]       cap_master,
  input logic [ADDR_W-1:0] cap_addr,
  input logic [31:0]       limit,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_wdata
);
  // R2: illegal limits leave the register untouched
  assert_bad_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd0 && (reg_wdata == 32'd0 || reg_wdata == 32'hFFFF_FFFF))
    |=> $stable(limit));

  // R4: a response in the limit cycle beats the timeout
  assert_rsp_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_busy && (tgt_ack || tgt_abort)) |-> !bus_err_resp);

  // R7: a valid capture names exactly one master
  assert_master_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> ($countones(cap_master) == 1));

  // R8: held capture does not move
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !release_cmd) |=> ($stable(cap_addr) && $stable(cap_master)));

  // R9: the two interrupt lines never rise together
  assert_irq_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_timeout && irq_abort));

  // R10: release without a new error silences both lines
  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (release_cmd && !tmo_evt && !abort_evt) |=> (!irq_timeout && !irq_abort));

  // R11: release and timeout together keep the new capture
  assert_release_vs_tmo_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (release_cmd && tmo_evt) |=> irq_timeout);

  // R12: no interrupt without a valid capture
  assert_no_irq_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_valid |-> (!irq_timeout && !irq_abort));
endmodule

bind bus_err_monitor bus_err_monitor_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq_timeout  (irq_timeout),
  .irq_abort    (irq_abort),
  .bus_err_resp (bus_err_resp),
  .txn_busy     (txn_busy),
  .tgt_ack      (tgt_ack),
  .tgt_abort    (tgt_abort),
  .tmo_evt      (tmo_evt),
  .abort_evt    (abort_evt),
  .release_cmd  (release_cmd),
  .cap_valid    (cap_valid),
  .cap_master   (cap_master),
  .cap_addr     (cap_addr),
  .limit        (limit),
  .reg_we       (reg_we),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata)
);

// File: tb/bus_err_monitor_bench.sv
`timescale 1ns/1ps
module bus_err_monitor_bench;
  localparam int ADDR_W = 40;
  localparam int MID_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              mon_grant, mon_write, tgt_ack, tgt_abort, reg_we;
  logic [ADDR_W-1:0] mon_addr;
  logic [3:0]        mon_strb;
  logic [MID_W-1:0]  mon_mid;
  logic [2:0]        reg_addr;
  logic [31:0]       reg_wdata, reg_rdata;
  logic              bus_err_resp, irq_timeout, irq_abort;

  always #2 clk = ~clk;

  bus_err_monitor #(.ADDR_W(ADDR_W), .MID_W(MID_W), .TMO_RST(32'd1024)) u_bus_err_monitor (
    .clk(clk), .rst_n(rst_n),
    .mon_grant(mon_grant), .mon_addr(mon_addr), .mon_write(mon_write),
    .mon_strb(mon_strb), .mon_mid(mon_mid),
    .tgt_ack(tgt_ack), .tgt_abort(tgt_abort), .bus_err_resp(bus_err_resp),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_timeout(irq_timeout), .irq_abort(irq_abort)
  );

  int checks = 0;
  int errors = 0;

  // Behavioural reference: a single outstanding transaction and one held record
  bit          m_busy, m_valid, m_to, m_ta;
  int unsigned m_age, m_limit;

  function automatic bit model_expire();
    return m_busy && !tgt_ack && !tgt_abort && (m_age >= m_limit);
  endfunction

  always @(posedge clk) begin
    bit exp_now, ta_now, rel;
    if (!rst_n) begin
      m_busy = 0; m_valid = 0; m_to = 0; m_ta = 0; m_age = 0; m_limit = 1024;
    end else begin
      exp_now = model_expire();
      ta_now  = m_busy && tgt_abort;
      rel     = reg_we && reg_addr == 3'd1 && reg_wdata[0];
      if ((exp_now || ta_now) && (!m_valid || rel)) begin
        m_valid = 1; m_to = exp_now; m_ta = ta_now && !exp_now;
      end else if (rel) m_valid = 0;
      if (reg_we && reg_addr == 3'd0 && reg_wdata != 32'd0 && reg_wdata != 32'hFFFF_FFFF)
        m_limit = reg_wdata;
      if (mon_grant) begin m_busy = 1; m_age = 1; end
      else if (m_busy) begin
        if (tgt_ack || tgt_abort || exp_now) m_busy = 0;
        else m_age++;
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stat(bit wr, logic [3:0] st, bit ta, bit to);
    return 32'(1) | (32'(wr) << 1) | (32'(st) << 2) | (32'(ta) << 11) | (32'(to) << 12);
  endfunction

  // One clock: compare against the model, then advance
  task automatic tick();
    #1;
    check("bus_err_resp R3 R4 R5", bus_err_resp, model_expire());
    check("irq_timeout R9", irq_timeout, m_valid && m_to);
    check("irq_abort R9", irq_abort, m_valid && m_ta);
    @(posedge clk);
    @(negedge clk);
    mon_grant = 0; tgt_ack = 0; tgt_abort = 0; reg_we = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic grant(input logic [ADDR_W-1:0] a, input bit wr, input logic [3:0] st,
                       input logic [MID_W-1:0] id);
    mon_grant = 1; mon_addr = a; mon_write = wr; mon_strb = st; mon_mid = id;
    tick();
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick();
  endtask

  task automatic rreg(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; mon_grant = 0; mon_addr = '0; mon_write = 0; mon_strb = '0; mon_mid = '0;
    tgt_ack = 0; tgt_abort = 0; reg_we = 0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("reset irq R1", {irq_timeout, irq_abort, bus_err_resp}, 3'b000);
    rreg(3'd4, 32'd0, "reset status R1");
    rreg(3'd0, 32'd1024, "reset limit R1");

    // R2 limit writes
    wreg(3'd0, 32'd0);
    rreg(3'd0, 32'd1024, "limit zero ignored R2");
    wreg(3'd0, 32'hFFFF_FFFF);
    rreg(3'd0, 32'd1024, "limit all-ones ignored R2");
    wreg(3'd0, 32'd6);
    rreg(3'd0, 32'd6, "limit load R2");

    // R4 ack exactly in the limit cycle
    grant(40'h00_0000_0100, 0, 4'hF, 4'd2);
    idle(5);
    tgt_ack = 1; tick();
    idle(2);
    rreg(3'd4, 32'd0, "no capture after late ack R4 R12");

    // R5 regrant restarts the count
    grant(40'h00_0000_0200, 0, 4'h1, 4'd2);
    idle(4);
    grant(40'h00_0000_0300, 1, 4'h2, 4'd7);
    idle(5);
    tgt_ack = 1; tick();
    rreg(3'd4, 32'd0, "regrant no capture R5");

    // R3 timeout capture, R7 fields
    grant(40'hAB_1234_5678, 1, 4'hA, 4'd3);
    idle(6);
    idle(1);
    rreg(3'd4, stat(1, 4'hA, 0, 1), "timeout status R3 R7");
    rreg(3'd3, 32'h1234_5678, "addr low R7");
    rreg(3'd2, 32'h0000_00AB, "addr high R7");
    rreg(3'd5, 32'h0000_0008, "master one-hot R7");

    // R8 later abort does not overwrite
    grant(40'h01_0000_0001, 0, 4'h1, 4'd1);
    tgt_abort = 1; tick();
    idle(1);
    rreg(3'd4, stat(1, 4'hA, 0, 1), "held status R8");
    rreg(3'd3, 32'h1234_5678, "held addr R8");
    rreg(3'd5, 32'h0000_0008, "held master R8");

    // R10 release with bit 0 clear then set
    wreg(3'd1, 32'hFFFF_FFFE);
    rreg(3'd4, stat(1, 4'hA, 0, 1), "release bit0 clear ignored R10");
    wreg(3'd1, 32'd1);
    rreg(3'd4, 32'd0, "released status R10 R12");
    idle(1);

    // R6 target abort capture
    grant(40'h00_0000_1000, 0, 4'h3, 4'd0);
    tick();
    tgt_abort = 1; tick();
    idle(1);
    rreg(3'd4, stat(0, 4'h3, 1, 0), "abort status R6");
    rreg(3'd5, 32'h0000_0001, "abort master R6 R7");

    // R11 release in the same cycle as a new timeout
    grant(40'h55_0000_0040, 0, 4'hF, 4'd5);
    idle(5);
    reg_we = 1; reg_addr = 3'd1; reg_wdata = 32'd1;
    tick();
    idle(1);
    rreg(3'd4, stat(0, 4'hF, 0, 1), "release+timeout status R11");
    rreg(3'd3, 32'h0000_0040, "release+timeout addr R11");
    rreg(3'd2, 32'h0000_0055, "release+timeout addr high R11");
    rreg(3'd5, 32'h0000_0020, "release+timeout master R11");
    wreg(3'd1, 32'd1);
    idle(2);
    rreg(3'd4, 32'd0, "final release R10");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule